// File: doc/BRIEF.md
# Registered Narrow-to-Wide Bus Exchanger

This block moves words between a narrow port A and a wide side made of two halves, 1B and 2B, each as wide as port A. The two halves together form a double-width bus that runs at half the word rate of port A. All capture happens on the rising clock edge. A select input steers the pairing, a direction input picks which side drives, and an active-low output enable can release every port.

Going from narrow to wide, two consecutive narrow words become one wide pair. The first word enters a two-stage path toward 1B and the second enters a single register toward 2B, so both halves change on the same edge. Going from wide to narrow, the 2B half reaches port A on a select-low edge. On that same edge the 1B half is parked, and it reaches port A on the following select-high edge.

Port drive is modelled as one enable flag per port, next to each data output. The direction input is registered, so a bus turnaround only happens on a clock edge. The output enable is not registered and acts at once. The block has no handshake. A word is taken on every edge, as the select input directs, so no back-pressure applies: the neighbour paces the transfer through the select input alone.

Top module: `nw_bus_exchanger`

## Requirements
- R1: A synchronous reset clears every data output to zero and sets the registered direction to wide-to-narrow (value 0). After reset, with `oe_n` low, only `a_oe` is 1.
- R2: While `oe_n` is 1, `a_oe`, `b1_oe` and `b2_oe` are all 0. This takes effect in the same cycle, with no edge needed.
- R3: A change on `dir` changes the enable flags only after the next rising edge.
- R4: With `oe_n` low and registered direction 1 (narrow-to-wide), `b1_oe` and `b2_oe` are 1 and `a_oe` is 0.
- R5: With `oe_n` low and registered direction 0 (wide-to-narrow), `a_oe` is 1 and `b1_oe` and `b2_oe` are 0.
- R6: An edge with `sel` = 0 loads `a_in` only into the first stage of the 1B path. `b1_out` and `b2_out` keep their values.
- R7: An edge with `sel` = 1 moves the first 1B stage to `b1_out` and loads `a_in` into `b2_out`, both on that edge.
- R8: An edge with `sel` = 0 loads `b2_in` into `a_out` and parks `b1_in` in a holding register.
- R9: An edge with `sel` = 1 loads the parked 1B word into `a_out`, not the `b1_in` present at that edge.
- R10: Both data paths update on every edge, whatever the direction and enable. The direction and enable affect only the drive flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low, not registered |
| dir | input | 1 | Direction request, 1 = narrow-to-wide, registered |
| sel | input | 1 | Half select / pipeline step |
| a_in | input | WORD_W | Narrow port receive data |
| a_out | output | WORD_W | Narrow port drive data |
| a_oe | output | 1 | Narrow port drive flag |
| b1_in | input | WORD_W | Half 1B receive data |
| b1_out | output | WORD_W | Half 1B drive data |
| b1_oe | output | 1 | Half 1B drive flag |
| b2_in | input | WORD_W | Half 2B receive data |
| b2_out | output | WORD_W | Half 2B drive data |
| b2_oe | output | 1 | Half 2B drive flag |

## Verification
The bench builds the block with `WORD_W` = 8, so each word in the vector table is a distinct byte. A word that leaks from the wrong stage, or from the current input instead of the parked one, therefore shows up as a wrong value. The table runs repeated select-low edges, direction flips while the enable is high, and pairs split across a turnaround. The directed tests look at the flags between edges to separate the combinational enable from the registered direction.

// File: rtl/xch_pkg.sv
package xch_pkg;
  typedef enum logic {
    XCH_WIDE_TO_NARROW = 1'b0,
    XCH_NARROW_TO_WIDE = 1'b1
  } xch_dir_e;
endpackage

// File: rtl/xch_turn_ctl.sv
module xch_turn_ctl
  import xch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  input  logic dir,
  output logic narrow_drive,
  output logic wide_drive
);
  xch_dir_e dir_q;

  always_ff @(posedge clk) begin
    if (rst) dir_q <= XCH_WIDE_TO_NARROW;
    else     dir_q <= xch_dir_e'(dir);
  end

  always_comb begin
    narrow_drive = !oe_n && (dir_q == XCH_WIDE_TO_NARROW);
    wide_drive   = !oe_n && (dir_q == XCH_NARROW_TO_WIDE);
  end
endmodule

// File: rtl/xch_fan_out.sv
module xch_fan_out #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [WORD_W-1:0] a_in,
  output logic [WORD_W-1:0] b1_q,
  output logic [WORD_W-1:0] b2_q
);
  logic [WORD_W-1:0] lead_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_q <= '0;
      b1_q   <= '0;
      b2_q   <= '0;
    end else if (!sel) begin
      lead_q <= a_in;
    end else begin
      b1_q <= lead_q;
      b2_q <= a_in;
    end
  end
endmodule

// File: rtl/xch_fan_in.sv
module xch_fan_in #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic [WORD_W-1:0] b1_in,
  input  logic [WORD_W-1:0] b2_in,
  output logic [WORD_W-1:0] a_q
);
  logic [WORD_W-1:0] park_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      park_q <= '0;
      a_q    <= '0;
    end else if (!sel) begin
      park_q <= b1_in;
      a_q    <= b2_in;
    end else begin
      a_q <= park_q;
    end
  end
endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oe_n,
  input  logic              dir,
  input  logic              sel,
  input  logic [WORD_W-1:0] a_in,
  output logic [WORD_W-1:0] a_out,
  output logic              a_oe,
  input  logic [WORD_W-1:0] b1_in,
  output logic [WORD_W-1:0] b1_out,
  output logic              b1_oe,
  input  logic [WORD_W-1:0] b2_in,
  output logic [WORD_W-1:0] b2_out,
  output logic              b2_oe
);
  logic wide_drive;

  xch_turn_ctl u_turn (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .narrow_drive(a_oe), .wide_drive(wide_drive)
  );

  xch_fan_out #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst(rst), .sel(sel), .a_in(a_in),
    .b1_q(b1_out), .b2_q(b2_out)
  );

  xch_fan_in #(.WORD_W(WORD_W)) u_in (
    .clk(clk), .rst(rst), .sel(sel), .b1_in(b1_in), .b2_in(b2_in),
    .a_q(a_out)
  );

  assign b1_oe = wide_drive;
  assign b2_oe = wide_drive;
endmodule

// File: rtl/nw_bus_exchanger_chk.sv
module nw_bus_exchanger_chk #(
  parameter int WORD_W = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              oe_n,
  input logic              dir,
  input logic              sel,
  input logic [WORD_W-1:0] a_in,
  input logic [WORD_W-1:0] a_out,
  input logic              a_oe,
  input logic [WORD_W-1:0] b1_in,
  input logic [WORD_W-1:0] b1_out,
  input logic              b1_oe,
  input logic [WORD_W-1:0] b2_in,
  input logic [WORD_W-1:0] b2_out,
  input logic              b2_oe
);
  p_release_r2: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b1_oe && !b2_oe));

  p_wide_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !$past(rst) && $past(dir)) |-> (b1_oe && b2_oe && !a_oe));

  p_narrow_drive_r5: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !$past(rst) && !$past(dir)) |-> (a_oe && !b1_oe && !b2_oe));

  p_lead_only_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel)) |-> ($stable(b1_out) && $stable(b2_out)));

  p_pair_load_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel)) |-> (b2_out == $past(a_in)));

  p_half2_first_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sel)) |-> (a_out == $past(b2_in)));

  p_parked_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(sel) && !$past(sel, 2) && !$past(rst, 2))
      |-> (a_out == $past(b1_in, 2)));
endmodule

bind nw_bus_exchanger nw_bus_exchanger_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/nw_bus_exchanger_bench.sv
module nw_bus_exchanger_bench;
  localparam int W = 8;

  typedef struct packed {
    logic         oe_n;
    logic         dir;
    logic         sel;
    logic [W-1:0] a;
    logic [W-1:0] b1;
    logic [W-1:0] b2;
    logic [W-1:0] ea;
    logic [W-1:0] eb1;
    logic [W-1:0] eb2;
    logic         eaoe;
    logic         eboe;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,8'h11,8'h00,8'h00, 8'h00,8'h00,8'h00, 1'b0,1'b1},
    '{1'b0,1'b1,1'b1,8'h22,8'h33,8'h44, 8'h00,8'h11,8'h22, 1'b0,1'b1},
    '{1'b0,1'b1,1'b0,8'h55,8'h66,8'h77, 8'h77,8'h11,8'h22, 1'b0,1'b1},
    '{1'b0,1'b1,1'b1,8'h88,8'h99,8'hAA, 8'h66,8'h55,8'h88, 1'b0,1'b1},
    '{1'b0,1'b0,1'b0,8'h01,8'hC1,8'hC2, 8'hC2,8'h55,8'h88, 1'b1,1'b0},
    '{1'b0,1'b0,1'b1,8'h02,8'hD1,8'hD2, 8'hC1,8'h01,8'h02, 1'b1,1'b0},
    '{1'b1,1'b0,1'b1,8'h03,8'hE1,8'hE2, 8'hC1,8'h01,8'h03, 1'b0,1'b0},
    '{1'b1,1'b1,1'b0,8'h04,8'hF1,8'hF2, 8'hF2,8'h01,8'h03, 1'b0,1'b0},
    '{1'b0,1'b1,1'b0,8'h05,8'hA1,8'hA2, 8'hA2,8'h01,8'h03, 1'b0,1'b1},
    '{1'b0,1'b1,1'b0,8'h06,8'hB1,8'hB2, 8'hB2,8'h01,8'h03, 1'b0,1'b1},
    '{1'b0,1'b1,1'b1,8'h07,8'h00,8'h00, 8'hB1,8'h06,8'h07, 1'b0,1'b1}
  };

  logic         clk = 1'b0;
  logic         rst, oe_n, dir, sel;
  logic [W-1:0] a_in, b1_in, b2_in, a_out, b1_out, b2_out;
  logic         a_oe, b1_oe, b2_oe;
  int           checks = 0;
  int           fails  = 0;

  always #2.5 clk = ~clk;

  nw_bus_exchanger #(.WORD_W(W)) u_nw_bus_exchanger (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir), .sel(sel),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic flags(input string tag, input logic ea, input logic eb);
    check(tag, {5'd0, a_oe, b1_oe, b2_oe}, {5'd0, ea, eb, eb});
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; oe_n = 1'b0; dir = 1'b1; sel = 1'b0;
    a_in = 8'hFF; b1_in = 8'hFF; b2_in = 8'hFF;
    repeat (2) @(posedge clk);
    #1;
    // R1: reset state, registered direction wide-to-narrow
    check("R1 a_out", a_out, 8'h00);
    check("R1 b1_out", b1_out, 8'h00);
    check("R1 b2_out", b2_out, 8'h00);
    flags("R1 flags", 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0; a_in = 8'h00; b1_in = 8'h00; b2_in = 8'h00; dir = 1'b0;
    @(posedge clk);
    #1;
    // R3: dir raised between edges, flags unchanged until next edge
    @(negedge clk);
    dir = 1'b1;
    #1;
    flags("R3 before edge", 1'b1, 1'b0);
    // R2: enable released without an edge
    oe_n = 1'b1;
    #1;
    flags("R2 immediate", 1'b0, 1'b0);
    oe_n = 1'b0;
    @(posedge clk);
    #1;
    flags("R3 after edge R4", 1'b0, 1'b1);

    // Vector walk: R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      oe_n = VEC[i].oe_n; dir = VEC[i].dir; sel = VEC[i].sel;
      a_in = VEC[i].a; b1_in = VEC[i].b1; b2_in = VEC[i].b2;
      @(posedge clk);
      #1;
      check($sformatf("R8 R9 a_out v%0d", i), a_out, VEC[i].ea);
      check($sformatf("R6 R7 b1_out v%0d", i), b1_out, VEC[i].eb1);
      check($sformatf("R6 R7 b2_out v%0d", i), b2_out, VEC[i].eb2);
      flags($sformatf("R4 R5 R10 flags v%0d", i), VEC[i].eaoe, VEC[i].eboe);
    end

    // R1: reset in mid-run clears data and returns direction
    @(negedge clk);
    rst = 1'b1; dir = 1'b1; oe_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 mid a_out", a_out, 8'h00);
    check("R1 mid b1_out", b1_out, 8'h00);
    check("R1 mid b2_out", b2_out, 8'h00);
    flags("R1 mid flags", 1'b1, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule